// File: doc/BRIEF.md
# ADC Result Register Read Interlock

This block keeps the most recent 10-bit result from an analog-to-digital converter and lets a CPU read it as two 8-bit read-only registers at adjacent addresses. The low-order register returns result bits 7..0. The high-order register returns result bits 9..8 in its two least significant positions. Reads have one cycle of latency. A converter sequencer supplies conversion-start and conversion-done pulses, the result value, the operating mode and a low-power indication. The block returns a one-cycle completion interrupt pulse, an end-of-conversion flag and a busy flag.

The central job is read coherence. Software reads the low byte first and then the high byte. From the cycle of the low-byte read through the cycle of the high-byte read, a completed conversion is not stored. The stored pair stays as it was, the new value is dropped, and no interrupt pulse is produced for it. Any result that is accepted writes both bytes on the same clock edge. A pair read outside a window therefore always comes from a single conversion.

Top module: `adc_result_interlock`

## Requirements
- R1: A read strobe at address LOW_ADDR (default 0x6) puts stored result bits 7..0 on `cpu_rdata` in the following cycle.
- R2: A read strobe at address LOW_ADDR+1 (default 0x7) puts stored result bits 9..8 on `cpu_rdata[1:0]` in the following cycle, with `cpu_rdata[7:2]` always 0.
- R3: A low-byte read opens a read window. The window covers the cycle of that read and every later cycle up to and including the cycle of the next high-byte read. A conversion-done pulse inside the window leaves the stored result unchanged, in single mode and in repeat mode alike.
- R4: A conversion-done pulse that is dropped under R3 produces no `irq` pulse.
- R5: A conversion-done pulse outside the window writes the whole 10-bit result on that clock edge. It also raises `irq` for exactly the following cycle.
- R6: Reset, `low_power` high, or `mode_sel` = 00 clears the stored result to 0 and closes the window. It also clears the end-of-conversion flag and the busy flag. While clearing is active, conversion-done pulses are ignored.
- R7: `eoc_flag` goes to 1 in the cycle after a result is accepted. It goes to 0 after a high-byte read or a `conv_start` pulse. When an acceptance and a clearing cause occur together, the flag ends at 1.
- R8: `busy` goes to 1 after `conv_start`. In single mode (`mode_sel` = 01) it goes to 0 after a conversion-done pulse. In repeat mode (`mode_sel` = 10 or 11) it stays at 1 until a clear under R6. A start in the same cycle as a done pulse leaves `busy` at 1.
- R9: In the cycle after a read strobe at any other address, or after a cycle with no read strobe, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Sequencer starts a conversion |
| conv_done | input | 1 | Sequencer finished a conversion, result valid this cycle |
| conv_result | input | 10 | Converted value |
| mode_sel | input | 2 | 00 off, 01 single, 10/11 repeat |
| low_power | input | 1 | A low-power mode (stop, idle or slow) is active |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 4 | CPU register address |
| cpu_rdata | output | 8 | Read data, one cycle after the strobe |
| irq | output | 1 | One-cycle conversion-complete interrupt pulse |
| eoc_flag | output | 1 | End-of-conversion flag |
| busy | output | 1 | Conversion in progress |

## Verification
The assertions check these properties on every cycle:
- the zero padding of the high byte;
- that a done pulse inside a window leaves the stored value alone and produces no interrupt;
- that every interrupt follows a done pulse and coincides with a set end-of-conversion flag;
- the effect of clearing;
- that busy follows a start;
- the zero read data for unmapped reads.

Some behaviour shows only in the bench's scenarios against its reference model. This covers whether the bytes returned by a low/high pair come from one conversion, and drops at the two window edges (a done pulse in the low-read cycle and in the high-read cycle). It also covers the single-mode versus repeat-mode difference in busy, and recovery after a low-power clear or a mode-off clear.

// File: rtl/adcrr_pkg.sv
package adcrr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF        = 2'b00,
        MODE_SINGLE     = 2'b01,
        MODE_REPEAT     = 2'b10,
        MODE_REPEAT_ALT = 2'b11
    } adc_mode_e;

    typedef struct packed {
        logic rd_low;
        logic rd_high;
        logic rd_other;
    } rd_req_t;

endpackage

// File: rtl/adcrr_decode.sv
module adcrr_decode
    import adcrr_pkg::*;
#(
    parameter int unsigned              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0]        LOW_ADDR = 'h6
) (
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output rd_req_t           req
);
    localparam logic [ADDR_W-1:0] HIGH_ADDR = LOW_ADDR + 1'b1;

    always_comb begin
        req          = '0;
        req.rd_low   = cpu_rd && (cpu_addr == LOW_ADDR);
        req.rd_high  = cpu_rd && (cpu_addr == HIGH_ADDR);
        req.rd_other = cpu_rd && !req.rd_low && !req.rd_high;
    end
endmodule

// File: rtl/adcrr_window.sv
module adcrr_window
    import adcrr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  rd_req_t req,
    input  logic    conv_done,
    output logic    accept,
    output logic    window_open
);
    typedef struct packed {
        logic pend;
    } win_state_t;

    win_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        if (clear) begin
            state_d.pend = 1'b0;
        end else begin
            // the low-read cycle already counts as inside the window
            accept = conv_done && !state_q.pend && !req.rd_low;
            if (req.rd_high) begin
                state_d.pend = 1'b0;
            end else if (req.rd_low) begin
                state_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign window_open = state_q.pend;
endmodule

// File: rtl/adcrr_store.sv
module adcrr_store #(
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [RES_W-1:0] conv_result,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic             single_mode,
    input  logic             rd_high,
    output logic [RES_W-1:0] result,
    output logic             eoc,
    output logic             irq,
    output logic             busy
);
    typedef struct packed {
        logic [RES_W-1:0] result;
        logic             eoc;
        logic             irq;
        logic             busy;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            st_d.irq = accept;
            if (accept) begin
                st_d.result = conv_result;
            end
            if (accept) begin
                st_d.eoc = 1'b1;
            end else if (rd_high || conv_start) begin
                st_d.eoc = 1'b0;
            end
            if (conv_start) begin
                st_d.busy = 1'b1;
            end else if (conv_done && single_mode) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign eoc    = st_q.eoc;
    assign irq    = st_q.irq;
    assign busy   = st_q.busy;
endmodule

// File: rtl/adcrr_readmux.sv
module adcrr_readmux
    import adcrr_pkg::*;
#(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_req_t           req,
    input  logic [RES_W-1:0]  result,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned HI_BITS = RES_W - DATA_W;
    localparam int unsigned PAD_W   = DATA_W - HI_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t rs_d, rs_q;
    logic [DATA_W-1:0] high_byte;

    assign high_byte = {{PAD_W{1'b0}}, result[RES_W-1:DATA_W]};

    always_comb begin
        rs_d = '0;
        if (req.rd_low) begin
            rs_d.data = result[DATA_W-1:0];
        end else if (req.rd_high) begin
            rs_d.data = high_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rdata = rs_q.data;
endmodule

// File: rtl/adc_result_interlock.sv
module adc_result_interlock
    import adcrr_pkg::*;
#(
    parameter int unsigned       RES_W    = 10,
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] LOW_ADDR = 'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [1:0]        mode_sel,
    input  logic              low_power,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq,
    output logic              eoc_flag,
    output logic              busy
);
    adc_mode_e        mode_e;
    logic             clear_req;
    logic             single_mode;
    rd_req_t          req;
    logic             accept;
    logic             window_open;
    logic [RES_W-1:0] result_q;

    assign mode_e      = adc_mode_e'(mode_sel);
    assign clear_req   = low_power || (mode_e == MODE_OFF);
    assign single_mode = (mode_e == MODE_SINGLE);

    adcrr_decode #(
        .ADDR_W   (ADDR_W),
        .LOW_ADDR (LOW_ADDR)
    ) u_decode (
        .cpu_rd   (cpu_rd),
        .cpu_addr (cpu_addr),
        .req      (req)
    );

    adcrr_window u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear_req),
        .req         (req),
        .conv_done   (conv_done),
        .accept      (accept),
        .window_open (window_open)
    );

    adcrr_store #(
        .RES_W (RES_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear_req),
        .accept      (accept),
        .conv_result (conv_result),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .single_mode (single_mode),
        .rd_high     (req.rd_high),
        .result      (result_q),
        .eoc         (eoc_flag),
        .irq         (irq),
        .busy        (busy)
    );

    adcrr_readmux #(
        .RES_W  (RES_W),
        .DATA_W (DATA_W)
    ) u_readmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .result (result_q),
        .rdata  (cpu_rdata)
    );
endmodule

// File: rtl/adcrr_checker.sv
module adcrr_checker #(
    parameter int unsigned       RES_W    = 10,
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] LOW_ADDR = 'h6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              conv_start,
    input logic              conv_done,
    input logic              clear_req,
    input logic              window_open,
    input logic [RES_W-1:0]  result_q,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              irq,
    input logic              eoc_flag,
    input logic              busy
);
    localparam logic [ADDR_W-1:0] HIGH_ADDR = LOW_ADDR + 1'b1;
    localparam int unsigned       HI_BITS   = RES_W - DATA_W;

    logic rd_low_p, rd_high_p, rd_other_p;
    assign rd_low_p   = cpu_rd && (cpu_addr == LOW_ADDR);
    assign rd_high_p  = cpu_rd && (cpu_addr == HIGH_ADDR);
    assign rd_other_p = !rd_low_p && !rd_high_p;

    a_r2_high_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_high_p |=> (cpu_rdata[DATA_W-1:HI_BITS] == '0));

    // R3 and R4: a drop keeps the stored value and emits no interrupt
    a_r4_window_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((window_open || rd_low_p) && conv_done && !clear_req) |=> (!irq && $stable(result_q)));

    a_r5_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(conv_done));

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (result_q == '0 && !eoc_flag && !window_open && !busy && !irq));

    a_r7_irq_sets_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eoc_flag);

    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !clear_req) |=> busy);

    a_r9_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other_p |=> (cpu_rdata == '0));
endmodule

bind adc_result_interlock adcrr_checker #(
    .RES_W    (RES_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LOW_ADDR (LOW_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd      (cpu_rd),
    .cpu_addr    (cpu_addr),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .clear_req   (clear_req),
    .window_open (window_open),
    .result_q    (result_q),
    .cpu_rdata   (cpu_rdata),
    .irq         (irq),
    .eoc_flag    (eoc_flag),
    .busy        (busy)
);

// File: tb/adc_result_interlock_tb.sv
module adc_result_interlock_tb;
    localparam int LOW  = 6;
    localparam int HIGH = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_start = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [1:0] mode_sel = 2'b01;
    logic       low_power = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_rdata;
    logic       irq, eoc_flag, busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit model_live = 0;

    // reference model state
    int m_res, m_rdata;
    bit m_pend, m_eoc, m_busy, m_irq;

    always #2.5 clk = ~clk;

    adc_result_interlock u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .mode_sel(mode_sel), .low_power(low_power),
        .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
        .irq(irq), .eoc_flag(eoc_flag), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_res = 0; m_pend = 0; m_eoc = 0; m_busy = 0; m_irq = 0; m_rdata = 0;
        end else begin
            bit clr, rdl, rdh, acc;
            clr = low_power || (mode_sel == 2'b00);
            rdl = cpu_rd && (cpu_addr == LOW);
            rdh = cpu_rd && (cpu_addr == HIGH);
            m_rdata = rdl ? (m_res % 256) : (rdh ? (m_res / 256) : 0);
            if (clr) begin
                m_res = 0; m_pend = 0; m_eoc = 0; m_busy = 0; m_irq = 0;
            end else begin
                acc = conv_done && !m_pend && !rdl;
                m_irq = acc;
                if (rdh) m_pend = 0;
                else if (rdl) m_pend = 1;
                if (acc) m_res = conv_result;
                if (acc) m_eoc = 1;
                else if (rdh || conv_start) m_eoc = 0;
                if (conv_start) m_busy = 1;
                else if (conv_done && mode_sel == 2'b01) m_busy = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_live) begin
            chk("R1 R2 R9 rdata model", cpu_rdata, m_rdata);
            chk("R4 R5 irq model", irq, m_irq);
            chk("R7 eoc model", eoc_flag, m_eoc);
            chk("R8 busy model", busy, m_busy);
        end
    end

    // call just after a negedge; returns at the next negedge
    task automatic cyc(input bit rd, input int addr, input bit done, input int res, input bit start);
        cpu_rd = rd; cpu_addr = addr[3:0]; conv_done = done;
        conv_result = res[9:0]; conv_start = start;
        @(negedge clk);
        cpu_rd = 0; conv_done = 0; conv_start = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_live = 1;
        @(negedge clk);
        // R6: reset state
        chk("R6 reset eoc", eoc_flag, 0);
        chk("R6 reset busy", busy, 0);
        cyc(1, LOW, 0, 0, 0);
        chk("R6 reset low byte", cpu_rdata, 0);
        cyc(1, HIGH, 0, 0, 0);
        chk("R6 reset high byte", cpu_rdata, 0);

        // single conversion
        cyc(0, 0, 0, 0, 1);
        chk("R8 busy after start", busy, 1);
        idle(2);
        cyc(0, 0, 1, 'h2A5, 0);
        chk("R5 irq pulse", irq, 1);
        chk("R7 eoc set", eoc_flag, 1);
        chk("R8 single busy cleared", busy, 0);
        idle(1);
        chk("R5 irq one cycle", irq, 0);
        cyc(1, LOW, 0, 0, 0);
        chk("R1 low byte", cpu_rdata, 'hA5);
        cyc(1, HIGH, 0, 0, 0);
        chk("R2 high byte", cpu_rdata, 'h02);
        chk("R7 eoc cleared by high read", eoc_flag, 0);

        // drop inside window
        cyc(0, 0, 1, 'h0F0, 0);
        cyc(1, LOW, 0, 0, 0);
        chk("R1 low of new", cpu_rdata, 'hF0);
        cyc(0, 0, 1, 'h155, 0);
        chk("R4 no irq in window", irq, 0);
        cyc(1, HIGH, 0, 0, 0);
        chk("R3 high kept", cpu_rdata, 'h00);
        cyc(1, LOW, 0, 0, 0);
        chk("R3 low kept", cpu_rdata, 'hF0);
        // still in window: done coincident with high read is dropped
        cyc(1, HIGH, 1, 'h3C3, 0);
        chk("R3 high read edge drop", irq, 0);
        // done coincident with low read is dropped
        cyc(1, LOW, 1, 'h3FF, 0);
        chk("R4 low read edge no irq", irq, 0);
        chk("R3 low read edge data", cpu_rdata, 'hF0);
        cyc(1, HIGH, 0, 0, 0);
        chk("R3 low read edge high", cpu_rdata, 'h00);

        // high read outside window, done alongside, accepted
        cyc(1, HIGH, 1, 'h1AB, 0);
        chk("R5 accept beside lone high read", irq, 1);
        chk("R7 set wins over high read", eoc_flag, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R7 eoc cleared by start", eoc_flag, 0);

        // repeat mode
        mode_sel = 2'b10;
        cyc(0, 0, 1, 'h3FF, 0);
        chk("R8 repeat busy stays", busy, 1);
        cyc(1, HIGH, 0, 0, 0);
        chk("R2 high pad zero", cpu_rdata, 'h03);
        cyc(1, LOW, 0, 0, 0);
        cyc(0, 0, 1, 'h001, 0);
        chk("R3 repeat drop", irq, 0);
        cyc(1, HIGH, 0, 0, 0);
        chk("R3 repeat high kept", cpu_rdata, 'h03);
        cyc(0, 0, 1, 'h200, 1);
        chk("R8 start wins busy", busy, 1);

        // unmapped read
        cyc(1, 3, 0, 0, 0);
        chk("R9 other address", cpu_rdata, 0);
        idle(1);
        chk("R9 no read zero", cpu_rdata, 0);

        // low-power clear, with window open
        cyc(1, LOW, 0, 0, 0);
        low_power = 1'b1;
        cyc(0, 0, 1, 'h155, 0);
        low_power = 1'b0;
        chk("R6 low power busy", busy, 0);
        chk("R6 low power no irq", irq, 0);
        cyc(1, LOW, 0, 0, 0);
        chk("R6 low power low", cpu_rdata, 0);
        cyc(1, HIGH, 0, 0, 0);
        chk("R6 low power high", cpu_rdata, 0);

        // window closed by clear: accept works afterwards
        mode_sel = 2'b01;
        cyc(0, 0, 1, 'h321, 0);
        chk("R5 accept after clear", irq, 1);
        mode_sel = 2'b00;
        idle(1);
        mode_sel = 2'b01;
        chk("R6 mode off eoc", eoc_flag, 0);
        cyc(1, LOW, 0, 0, 0);
        chk("R6 mode off low", cpu_rdata, 0);
        cyc(1, HIGH, 0, 0, 0);
        chk("R6 mode off high", cpu_rdata, 0);

        // back-to-back accepts
        cyc(0, 0, 1, 'h111, 0);
        cyc(0, 0, 1, 'h2EE, 0);
        chk("R5 second accept irq", irq, 1);
        cyc(1, LOW, 0, 0, 0);
        chk("R1 latest low", cpu_rdata, 'hEE);
        cyc(1, HIGH, 0, 0, 0);
        chk("R2 latest high", cpu_rdata, 'h02);
        idle(3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule